// File: doc/BRIEF.md
# Vectored Interrupt Controller, 64 Inputs

The block gathers 64 interrupt lines and turns each one that is pending, unmasked and enabled for messaging into a single outbound message. The message carries an 8-bit vector and an 8-bit route byte programmed for that line, plus the line's number. Messages leave over a valid/ready channel.

Software programs the block through a simple 32-bit register bus. Per line it sets:

- edge or level sensing, and the active polarity;
- a mask bit and a message-enable bit;
- a vector byte and a route byte.

A write-one clear register discards latched edge events and re-arms level lines. A read-only identity word reports how many lines are built in. Two further words only hold a value written to them, with no function behind it.

Top module: `irqv_top`

## Requirements
- R1: After reset every mask bit is 1, and the enable, edge, polarity, holding-only and route registers read 0. Each vector byte equals its line number, and no message is valid. The word at offset 0x004 reads (NSRC-1) in bits 23:16, which is bits 55:48 of the 64-bit identity word at offset 0.
- R2: Register word offsets are as follows: mask 0x020/0x024, message enable 0x040/0x044, edge select 0x060/0x064, clear 0x080/0x084, holding-only 0x0C0/0x0C4 and 0x0E0/0x0E4, polarity 0x3E0/0x3E4. The first word of each pair holds lines 0-31 and the second holds lines 32-63, with bit = line mod 32. The route byte of line n sits at byte address 0x100+n and the vector byte at 0x200+n, in byte lane n mod 4 of the word at the address rounded down to a multiple of 4. Writes honour the byte enables. Read data appears in the cycle after the read request.
- R3: A line with edge bit 0 is level sensed and is active when its input XOR its polarity bit is 1. Polarity 0 means active-high and polarity 1 means active-low. An active line yields one message per activation. It yields another only after it goes inactive or after a clear write to its bit.
- R4: A line with edge bit 1 latches an event on the selected transition: rising when polarity is 0, falling when polarity is 1. The latch holds while the line is masked. Each event yields exactly one message, and taking the message into the output clears the latch.
- R5: Writing 1 to a bit of the clear register discards that line's latched edge event and re-arms a level line. Bits written 0 have no effect, and the clear register reads 0.
- R6: A line whose mask bit is 1, or whose enable bit is 0, produces no message. Its pending state is kept until it is let through.
- R7: When several lines qualify at once, the lowest-numbered line is sent first.
- R8: A message carries the line's vector byte, route byte and line number. While valid is high and ready is low, valid and all message fields stay unchanged.
- R9: The holding-only words read back what was written, under the byte enables, and have no effect on messages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Interrupt lines, synchronous to clk |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Receiver takes the message |
| msg_vector | output | 8 | Vector byte of the line sent |
| msg_route | output | 8 | Route byte of the line sent |
| msg_source | output | 6 | Number of the line sent |

## Verification
The corruptions that matter each show up at the message port within a few cycles. A stuck edge latch shows as an extra copy of a message right after the first one is taken. A lost latch shows as a missing message when a masked line is released. A broken level re-arm shows as a flood of identical vectors, or as silence after a clear write. A wrong priority or a bad vector or route store shows in the first message after a multi-line burst, and a register decode fault shows in the read one cycle after the access.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_ID    = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_MSGEN = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_EDGE  = 12'h060;
  localparam logic [ADDR_W-1:0] OFS_CLEAR = 12'h080;
  localparam logic [ADDR_W-1:0] OFS_HOLD0 = 12'h0C0;
  localparam logic [ADDR_W-1:0] OFS_HOLD1 = 12'h0E0;
  localparam logic [ADDR_W-1:0] OFS_ROUTE = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_VEC   = 12'h200;
  localparam logic [ADDR_W-1:0] OFS_POL   = 12'h3E0;

  // expand byte enables to a bit mask
  function automatic logic [31:0] lane_bits(input logic [3:0] be);
    logic [31:0] m;
    for (int l = 0; l < 4; l++) m[8*l +: 8] = {8{be[l]}};
    return m;
  endfunction

  function automatic logic [31:0] merge_be(input logic [31:0] old_w,
                                           input logic [31:0] new_w,
                                           input logic [3:0]  be);
    logic [31:0] m;
    m = lane_bits(be);
    return (old_w & ~m) | (new_w & m);
  endfunction

endpackage

// File: rtl/irqv_regs.sv
module irqv_regs
  import irqv_pkg::*;
#(
  parameter int NSRC = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [3:0]            bus_be,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [NSRC-1:0]       mask_o,
  output logic [NSRC-1:0]       en_o,
  output logic [NSRC-1:0]       edge_o,
  output logic [NSRC-1:0]       pol_o,
  output logic [NSRC-1:0]       clr_o,
  output logic [NSRC*8-1:0]     route_o,
  output logic [NSRC*8-1:0]     vec_o
);

  localparam int NWORD = NSRC / 32;
  localparam logic [7:0] ID_FIELD = 8'(NSRC - 1);

  logic [NWORD-1:0][31:0] mask_q, mask_d, en_q, en_d, edge_q, edge_d;
  logic [NWORD-1:0][31:0] pol_q, pol_d, hold0_q, hold0_d, hold1_q, hold1_d;
  logic [NSRC-1:0][7:0]   route_q, route_d, vec_q, vec_d;
  logic [31:0]            rdata_q, rdata_d;
  logic                   wr_en, rd_en;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  // next state and read mux
  always_comb begin
    mask_d  = mask_q;
    en_d    = en_q;
    edge_d  = edge_q;
    pol_d   = pol_q;
    hold0_d = hold0_q;
    hold1_d = hold1_q;
    route_d = route_q;
    vec_d   = vec_q;
    clr_o   = '0;
    rdata_d = '0;
    if (bus_addr == OFS_ID + 12'd4) rdata_d = {8'h00, ID_FIELD, 16'h0000};
    for (int w = 0; w < NWORD; w++) begin
      if (bus_addr == OFS_MASK + 12'(4*w)) begin
        rdata_d = mask_q[w];
        if (wr_en) mask_d[w] = merge_be(mask_q[w], bus_wdata, bus_be);
      end
      if (bus_addr == OFS_MSGEN + 12'(4*w)) begin
        rdata_d = en_q[w];
        if (wr_en) en_d[w] = merge_be(en_q[w], bus_wdata, bus_be);
      end
      if (bus_addr == OFS_EDGE + 12'(4*w)) begin
        rdata_d = edge_q[w];
        if (wr_en) edge_d[w] = merge_be(edge_q[w], bus_wdata, bus_be);
      end
      if (bus_addr == OFS_POL + 12'(4*w)) begin
        rdata_d = pol_q[w];
        if (wr_en) pol_d[w] = merge_be(pol_q[w], bus_wdata, bus_be);
      end
      if (bus_addr == OFS_HOLD0 + 12'(4*w)) begin
        rdata_d = hold0_q[w];
        if (wr_en) hold0_d[w] = merge_be(hold0_q[w], bus_wdata, bus_be);
      end
      if (bus_addr == OFS_HOLD1 + 12'(4*w)) begin
        rdata_d = hold1_q[w];
        if (wr_en) hold1_d[w] = merge_be(hold1_q[w], bus_wdata, bus_be);
      end
      if (wr_en && bus_addr == OFS_CLEAR + 12'(4*w))
        clr_o[w*32 +: 32] = bus_wdata & lane_bits(bus_be);
    end
    for (int s = 0; s < NSRC; s++) begin
      if (bus_addr[ADDR_W-1:2] == 10'(int'(OFS_ROUTE >> 2) + s/4)) begin
        rdata_d[8*(s%4) +: 8] = route_q[s];
        if (wr_en && bus_be[s%4]) route_d[s] = bus_wdata[8*(s%4) +: 8];
      end
      if (bus_addr[ADDR_W-1:2] == 10'(int'(OFS_VEC >> 2) + s/4)) begin
        rdata_d[8*(s%4) +: 8] = vec_q[s];
        if (wr_en && bus_be[s%4]) vec_d[s] = bus_wdata[8*(s%4) +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      en_q    <= '0;
      edge_q  <= '0;
      pol_q   <= '0;
      hold0_q <= '0;
      hold1_q <= '0;
      route_q <= '0;
      for (int s = 0; s < NSRC; s++) vec_q[s] <= 8'(s);
      rdata_q <= '0;
    end else begin
      if (wr_en) begin
        mask_q  <= mask_d;
        en_q    <= en_d;
        edge_q  <= edge_d;
        pol_q   <= pol_d;
        hold0_q <= hold0_d;
        hold1_q <= hold1_d;
        route_q <= route_d;
        vec_q   <= vec_d;
      end
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign mask_o    = mask_q;
  assign en_o      = en_q;
  assign edge_o    = edge_q;
  assign pol_o     = pol_q;
  assign route_o   = route_q;
  assign vec_o     = vec_q;

endmodule

// File: rtl/irqv_detect.sv
module irqv_detect #(
  parameter int NSRC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [NSRC-1:0] edge_i,
  input  logic [NSRC-1:0] pol_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] served_i,
  output logic [NSRC-1:0] qual_o
);

  logic [NSRC-1:0] pend;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic act, evt, prev_q, lat_q, lat_d, sent_q, sent_d;

    always_comb begin
      act    = irq_in[i] ^ pol_i[i];
      evt    = edge_i[i] & act & ~prev_q;
      // a new event wins over a clear in the same cycle
      lat_d  = ((lat_q & ~clr_i[i] & ~served_i[i]) | evt) & edge_i[i];
      sent_d = (sent_q | (served_i[i] & ~edge_i[i])) & act & ~clr_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        lat_q  <= 1'b0;
        sent_q <= 1'b0;
      end else begin
        prev_q <= act;
        lat_q  <= lat_d;
        sent_q <= sent_d;
      end
    end

    assign pend[i] = edge_i[i] ? lat_q : (act & ~sent_q);
  end

  assign qual_o = pend & ~mask_i & en_i;

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
  parameter int NSRC = 64,
  localparam int SW = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   qual_i,
  input  logic [NSRC*8-1:0] vec_i,
  input  logic [NSRC*8-1:0] route_i,
  input  logic              msg_ready,
  output logic              msg_valid,
  output logic [7:0]        msg_vector,
  output logic [7:0]        msg_route,
  output logic [SW-1:0]     msg_source,
  output logic [NSRC-1:0]   served_o
);

  logic [SW-1:0] pick;
  logic          found, load, valid_q, valid_d;
  logic [7:0]    vec_q, route_q;
  logic [SW-1:0] src_q;

  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (qual_i[i]) begin
        pick  = SW'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    load     = found & (~valid_q | msg_ready);
    served_o = '0;
    if (load) served_o[pick] = 1'b1;
    if (load)           valid_d = 1'b1;
    else if (msg_ready) valid_d = 1'b0;
    else                valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      route_q <= '0;
      src_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (load) begin
        vec_q   <= vec_i[8*pick +: 8];
        route_q <= route_i[8*pick +: 8];
        src_q   <= pick;
      end
    end
  end

  assign msg_valid  = valid_q;
  assign msg_vector = vec_q;
  assign msg_route  = route_q;
  assign msg_source = src_q;

endmodule

// File: rtl/irqv_top.sv
module irqv_top
  import irqv_pkg::*;
#(
  parameter int NSRC = 64,
  localparam int SW = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_vector,
  output logic [7:0]        msg_route,
  output logic [SW-1:0]     msg_source
);

  logic [1:0]        rst_sync;
  logic              rst_q;
  logic [NSRC-1:0]   mask_w, en_w, edge_w, pol_w, clr_w, qual, served;
  logic [NSRC*8-1:0] route_w, vec_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  irqv_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_q),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mask_o(mask_w), .en_o(en_w), .edge_o(edge_w), .pol_o(pol_w),
    .clr_o(clr_w), .route_o(route_w), .vec_o(vec_w)
  );

  irqv_detect #(.NSRC(NSRC)) u_detect (
    .clk(clk), .rst_n(rst_q), .irq_in(irq_in),
    .edge_i(edge_w), .pol_i(pol_w), .mask_i(mask_w), .en_i(en_w),
    .clr_i(clr_w), .served_i(served), .qual_o(qual)
  );

  irqv_arbiter #(.NSRC(NSRC)) u_arb (
    .clk(clk), .rst_n(rst_q), .qual_i(qual),
    .vec_i(vec_w), .route_i(route_w), .msg_ready(msg_ready),
    .msg_valid(msg_valid), .msg_vector(msg_vector), .msg_route(msg_route),
    .msg_source(msg_source), .served_o(served)
  );

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
  import irqv_pkg::*;
#(
  parameter int NSRC = 64,
  localparam int SW = $clog2(NSRC)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [7:0]        msg_vector,
  input logic [7:0]        msg_route,
  input logic [SW-1:0]     msg_source,
  input logic [NSRC-1:0]   mask_q,
  input logic [NSRC-1:0]   en_q,
  input logic [NSRC-1:0]   qual,
  input logic [NSRC-1:0]   served
);

  logic [NSRC-1:0] below;
  assign below = (NSRC'(1) << msg_source) - NSRC'(1);

  // R1: identity field
  p_id_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == OFS_ID + 12'd4)
      |=> bus_rdata[23:16] == 8'(NSRC - 1));

  // R5: clear word reads zero
  p_clear_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == OFS_CLEAR || bus_addr == OFS_CLEAR + 12'd4))
      |=> bus_rdata == 32'd0);

  // R8: held under backpressure
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready)
      |=> msg_valid && $stable(msg_vector) && $stable(msg_route) && $stable(msg_source));

  // R6: a freshly loaded message came from an unmasked, enabled line
  p_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && (!$past(msg_valid) || $past(msg_ready)))
      |-> ((($past(mask_q) >> msg_source) & NSRC'(1)) == '0) &&
          ((($past(en_q) >> msg_source) & NSRC'(1)) != '0));

  // R7: nothing lower was qualifying when the message was chosen
  p_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && (!$past(msg_valid) || $past(msg_ready)))
      |-> (($past(qual) & below) == '0));

  // R4: at most one line is served per cycle
  p_single_serve_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(served));

endmodule

bind irqv_top irqv_checker #(.NSRC(NSRC)) u_irqv_checker (
  .clk(clk), .rst_n(rst_q),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
  .msg_route(msg_route), .msg_source(msg_source),
  .mask_q(mask_w), .en_q(en_w), .qual(qual), .served(served)
);

// File: tb/irqv_top_bench.sv
`timescale 1ns/1ps
module irqv_top_bench;

  localparam int NSRC = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        msg_valid, msg_ready = 1'b1;
  logic [7:0]  msg_vector, msg_route;
  logic [5:0]  msg_source;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] vec_model [64];
  logic [7:0] route_model [64];

  int         ccount = 0;
  int         cs [2048];
  logic [7:0] cv [2048];
  logic [7:0] cr [2048];

  always #2.5 clk = ~clk;

  irqv_top #(.NSRC(NSRC)) u_irqv_top (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_route(msg_route), .msg_source(msg_source)
  );

  // a message seen valid with ready at a falling edge is taken at the next rising edge
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready && ccount < 2048) begin
      cs[ccount] = int'(msg_source);
      cv[ccount] = msg_vector;
      cr[ccount] = msg_route;
      ccount++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp,
                        input string req, input string what);
    logic [31:0] d;
    rd(a, d);
    chk(d == exp, req, what, d, exp);
  endtask

  task automatic set_irq(input int s, input logic v);
    @(posedge clk); #1;
    irq_in[s] = v;
  endtask

  task automatic pulse(input logic [63:0] p);
    @(posedge clk); #1;
    irq_in = irq_in | p;
    @(posedge clk); #1;
    irq_in = irq_in & ~p;
  endtask

  task automatic wait_rand(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      msg_ready = 1'($urandom % 2);
    end
    @(posedge clk); #1;
    msg_ready = 1;
    idle(4);
  endtask

  function automatic int popc(input logic [63:0] p);
    int n = 0;
    for (int i = 0; i < 64; i++) n += int'(p[i]);
    return n;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int base;
    logic [31:0] d0;
    logic [7:0] hv;
    logic [7:0] hr;
    logic [5:0] hs;
    bit hold_ok;

    void'($urandom(32'd20240611));
    for (int s = 0; s < 64; s++) begin
      vec_model[s] = 8'(s);
      route_model[s] = 8'h00;
    end
    idle(3);
    rst_n = 1;
    idle(4);

    // R1 reset state
    @(negedge clk);
    chk(msg_valid == 0, "R1", "valid after reset", msg_valid, 0);
    rd_chk(12'h020, 32'hFFFF_FFFF, "R1", "mask word0");
    rd_chk(12'h024, 32'hFFFF_FFFF, "R1", "mask word1");
    rd_chk(12'h044, 32'h0, "R1", "enable word1");
    rd_chk(12'h060, 32'h0, "R1", "edge word0");
    rd_chk(12'h3E4, 32'h0, "R1", "polarity word1");
    rd_chk(12'h0C0, 32'h0, "R1", "hold word");
    rd_chk(12'h13C, 32'h0, "R1", "route bytes 60-63");
    rd_chk(12'h200, 32'h0302_0100, "R1", "vector bytes 0-3");
    rd_chk(12'h23C, 32'h3F3E_3D3C, "R1", "vector bytes 60-63");
    rd_chk(12'h004, 32'h003F_0000, "R1", "identity upper word");

    // R9 holding-only words
    wr(12'h0C4, 32'h1234_5678, 4'hF);
    rd_chk(12'h0C4, 32'h1234_5678, "R9", "hold0 word1 readback");
    wr(12'h0E0, 32'hFFFF_FFFF, 4'b0101);
    rd_chk(12'h0E0, 32'h00FF_00FF, "R9", "hold1 byte-enable write");

    // R2 byte writes of vector and route
    wr(12'h204, 32'h0000_5500, 4'b0010);  vec_model[5] = 8'h55;
    rd_chk(12'h204, 32'h0706_5504, "R2", "vector byte lane 1");
    wr(12'h104, 32'h0000_1100, 4'b0010);  route_model[5] = 8'h11;
    rd_chk(12'h104, 32'h0000_1100, "R2", "route byte lane 1");
    rd_chk(12'h080, 32'h0, "R5", "clear reads zero");

    wr(12'h040, 32'hFFFF_FFFF, 4'hF);
    wr(12'h044, 32'hFFFF_FFFF, 4'hF);

    // R3 level active-high on line 5
    wr(12'h020, ~32'h20, 4'hF);
    base = ccount;
    set_irq(5, 1);
    idle(6);
    chk(ccount - base == 1, "R3", "level line 5 one message", ccount - base, 1);
    chk(cv[base] == 8'h55 && cr[base] == 8'h11 && cs[base] == 5, "R8",
        "line 5 message fields", {cs[base], cv[base], cr[base]}, {32'd5, 8'h55, 8'h11});
    idle(10);
    chk(ccount - base == 1, "R3", "no repeat while held", ccount - base, 1);
    set_irq(5, 0); idle(2); set_irq(5, 1); idle(6);
    chk(ccount - base == 2, "R3", "re-armed after inactive", ccount - base, 2);
    wr(12'h080, 32'h20, 4'hF);
    idle(6);
    chk(ccount - base == 3, "R5", "clear re-arms level", ccount - base, 3);
    set_irq(5, 0);
    idle(3);

    // R6 mask and enable on line 6
    base = ccount;
    set_irq(6, 1);
    idle(6);
    chk(ccount - base == 0, "R6", "masked level silent", ccount - base, 0);
    wr(12'h040, ~32'h40, 4'hF);
    wr(12'h020, ~32'h60, 4'hF);
    idle(6);
    chk(ccount - base == 0, "R6", "disabled level silent", ccount - base, 0);
    wr(12'h040, 32'hFFFF_FFFF, 4'hF);
    idle(6);
    chk(ccount - base == 1 && cs[base] == 6, "R6", "released line 6 sends",
        ccount - base, 1);
    set_irq(6, 0);

    // R3 active-low level on line 7
    wr(12'h3E0, 32'h80, 4'hF);
    base = ccount;
    wr(12'h020, ~32'hE0, 4'hF);
    idle(6);
    chk(ccount - base == 1 && cs[base] == 7, "R3", "active-low line 7", ccount - base, 1);
    set_irq(7, 1); idle(3); set_irq(7, 0); idle(6);
    chk(ccount - base == 2, "R3", "active-low second activation", ccount - base, 2);

    // R4 rising edge on line 40
    wr(12'h064, 32'h100, 4'hF);
    wr(12'h024, ~32'h100, 4'hF);
    base = ccount;
    pulse(64'd1 << 40);
    idle(6);
    chk(ccount - base == 1 && cs[base] == 40 && cv[base] == 8'd40, "R4",
        "rising edge line 40", ccount - base, 1);
    set_irq(40, 1); idle(10); set_irq(40, 0); idle(4);
    chk(ccount - base == 2, "R4", "one message per event", ccount - base, 2);

    // R4 falling edge on line 41
    wr(12'h3E4, 32'h200, 4'hF);
    wr(12'h064, 32'h300, 4'hF);
    wr(12'h024, ~32'h300, 4'hF);
    idle(4);
    base = ccount;
    set_irq(41, 1); idle(6);
    chk(ccount - base == 0, "R4", "rise ignored with polarity 1", ccount - base, 0);
    set_irq(41, 0); idle(6);
    chk(ccount - base == 1 && cs[base] == 41, "R4", "falling edge line 41",
        ccount - base, 1);

    // R4 latch while masked, R5 clear on line 42
    wr(12'h064, 32'h700, 4'hF);
    base = ccount;
    pulse(64'd1 << 42);
    idle(6);
    chk(ccount - base == 0, "R6", "masked edge silent", ccount - base, 0);
    wr(12'h024, ~32'h700, 4'hF);
    idle(6);
    chk(ccount - base == 1 && cs[base] == 42, "R4", "latched edge after unmask",
        ccount - base, 1);
    wr(12'h024, ~32'h300, 4'hF);
    pulse(64'd1 << 42);
    wr(12'h084, 32'h400, 4'hF);
    wr(12'h024, ~32'h700, 4'hF);
    idle(6);
    chk(ccount - base == 1, "R5", "cleared edge discarded", ccount - base, 1);
    wr(12'h024, ~32'h300, 4'hF);
    pulse(64'd1 << 42);
    wr(12'h084, 32'h0, 4'hF);
    wr(12'h024, ~32'h700, 4'hF);
    idle(6);
    chk(ccount - base == 2, "R5", "zero clear bits no effect", ccount - base, 2);

    // R7 priority and R8 hold under backpressure
    wr(12'h060, 32'h08, 4'hF);
    wr(12'h020, ~32'hE8, 4'hF);
    idle(2);
    base = ccount;
    msg_ready = 0;
    pulse((64'd1 << 3) | (64'd1 << 40));
    idle(3);
    @(negedge clk);
    chk(msg_valid && msg_source == 6'd3, "R7", "lowest line first", msg_source, 3);
    hv = msg_vector; hr = msg_route; hs = msg_source;
    hold_ok = 1;
    repeat (4) begin
      @(negedge clk);
      if (!msg_valid || msg_vector != hv || msg_route != hr || msg_source != hs) hold_ok = 0;
    end
    chk(hold_ok, "R8", "stable while not ready", hold_ok, 1);
    @(posedge clk); #1; msg_ready = 1;
    idle(6);
    chk(ccount - base == 2 && cs[base] == 3 && cs[base+1] == 40, "R7",
        "order 3 then 40", cs[base+1], 40);

    // random edge bursts
    wr(12'h3E0, 32'h0, 4'hF); wr(12'h3E4, 32'h0, 4'hF);
    wr(12'h060, 32'hFFFF_FFFF, 4'hF); wr(12'h064, 32'hFFFF_FFFF, 4'hF);
    wr(12'h020, 32'h0, 4'hF); wr(12'h024, 32'h0, 4'hF);
    for (int w = 0; w < 16; w++) begin
      d0 = $urandom;
      wr(12'h200 + 12'(4*w), d0, 4'hF);
      for (int l = 0; l < 4; l++) vec_model[4*w+l] = d0[8*l +: 8];
    end
    idle(6);
    for (int r = 0; r < 20; r++) begin
      logic [63:0] p;
      bit ok_seq;
      int k;
      p = (r == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : {$urandom, $urandom};
      base = ccount;
      pulse(p);
      wait_rand(200);
      chk(ccount - base == popc(p), "R4", "burst message count", ccount - base, popc(p));
      ok_seq = 1; k = base;
      for (int s = 0; s < 64; s++) begin
        if (p[s]) begin
          if (k >= ccount || cs[k] != s || cv[k] != vec_model[s] || cr[k] != route_model[s])
            ok_seq = 0;
          k++;
        end
      end
      chk(ok_seq, "R7", "burst ascending order and fields", ok_seq, 1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule